// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This unit carries out the load-linked (LL) and store-conditional (SC) word operations of a 64-bit core. It holds a single link reservation. A decoded request carries a base register value, a 9-bit signed displacement and the low 32-bit word of the source register. The unit forms and checks the effective address. For an LL it opens a reservation on the addressed word. For an SC it decides whether the store may go ahead, places the word in the correct half of a 64-bit write lane with byte enables, and returns a success flag for write-back.

The data read of an LL is handled by the normal load path; this unit only records the reservation. The reservation is dropped when a snooped external write hits the reserved word, when the core takes an exception, and after every SC. Address translation is identity. Both endianness controls are static inputs.

Top module: `llsc_unit`

## Requirements
- R1: The effective address is `req_base_i` plus the 9-bit two's-complement `req_offset_i`, sign-extended to 64 bits. With both endianness controls low, it appears unchanged on `mem_addr_o`.
- R2: If effective-address bits [1:0] are not both zero, the unit pulses `addr_err_o` together with `done_o`, returns a result of 0 and issues no memory request. A misaligned LL opens no reservation.
- R3: An aligned SC that finds the link set issues exactly one memory write and completes with `result_o` = 1.
- R4: `result_o` is the link bit zero-extended to 64 bits. An SC that finds the link clear returns 0 and issues no memory request.
- R5: While `mem_req_o` is high and `mem_ready_i` is low, the address, data and byte enables hold steady. `done_o` rises in the cycle after the accepting `mem_ready_i`.
- R6: The byte select is address[2:0] XOR {`big_endian_i`, 2'b00}. The write data is the word shifted left by 8×select bits. `mem_be_o` is 4'hF shifted left by the select value, so it is either 8'h0F or 8'hF0.
- R7: `mem_addr_o` bit 2 is effective-address bit 2 XOR `reverse_endian_i`. All other bits are passed through unchanged.
- R8: An aligned LL sets the link and records the word address (effective address bits [63:2]). Every SC clears the link, whether it succeeds or fails.
- R9: A snoop whose word address equals the recorded one clears the link. A snoop to any other word leaves the link set.
- R10: An `exc_taken_i` pulse while a reservation is open clears the link.
- R11: `req_ready_o` is high only when the unit is idle. An LL completes with `done_o` one cycle after acceptance and a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_base_i | input | 64 | Base register value |
| req_offset_i | input | 9 | Signed displacement |
| req_data_i | input | 32 | Low word of the source register |
| req_ready_o | output | 1 | Unit idle, request accepted |
| big_endian_i | input | 1 | Static big-endian lane control |
| reverse_endian_i | input | 1 | Static reverse-endian address control |
| exc_taken_i | input | 1 | Exception taken by the core |
| snoop_valid_i | input | 1 | External write observed |
| snoop_tag_i | input | 62 | Word address (bits [63:2]) of the external write |
| mem_req_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_addr_o | output | 64 | Write address |
| mem_wdata_o | output | 64 | Write lane data |
| mem_be_o | output | 8 | Byte enables |
| done_o | output | 1 | Operation complete (one cycle) |
| result_o | output | 64 | Value for the destination register |
| addr_err_o | output | 1 | Address-error exception, valid with done_o |

## Verification
The bench builds the unit with its default widths: 64-bit data, a 9-bit displacement and 32-bit words. With these values both halves of the write lane are reachable, and both endianness controls can be exercised with select values 0 and 4. The displacement covers its full signed range, so both negative and positive offsets are tried. The memory model stalls for a chosen number of cycles, which exercises the hold-steady rule. An increment-retry loop with injected snoops and exceptions is checked against a reference counter.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_RESP  = 2'd2
  } llsc_state_e;

  localparam logic OP_LL = 1'b0;
  localparam logic OP_SC = 1'b1;
endpackage

// File: rtl/llsc_agen.sv
module llsc_agen #(
  parameter int XLEN   = 64,
  parameter int OFS_W  = 9,
  parameter int WORD_W = 32,
  localparam int BYTES   = XLEN / 8,
  localparam int LANE_W  = $clog2(BYTES),
  localparam int WBYTES  = WORD_W / 8,
  localparam int ALIGN_W = $clog2(WBYTES)
) (
  input  logic [XLEN-1:0]         base_i,
  input  logic [OFS_W-1:0]        offset_i,
  input  logic [WORD_W-1:0]       data_i,
  input  logic                    big_endian_i,
  input  logic                    reverse_endian_i,
  output logic [XLEN-ALIGN_W-1:0] tag_o,
  output logic                    misalign_o,
  output logic [XLEN-1:0]         paddr_o,
  output logic [XLEN-1:0]         lane_data_o,
  output logic [BYTES-1:0]        lane_be_o
);
  // flips between the two word halves of the lane
  localparam logic [LANE_W-1:0] HALF_MASK = LANE_W'(BYTES - WBYTES);

  logic [XLEN-1:0]   ea;
  logic [LANE_W-1:0] bytesel;

  always_comb begin
    ea          = base_i + {{(XLEN-OFS_W){offset_i[OFS_W-1]}}, offset_i};
    misalign_o  = |ea[ALIGN_W-1:0];
    tag_o       = ea[XLEN-1:ALIGN_W];
    bytesel     = ea[LANE_W-1:0] ^ (big_endian_i ? HALF_MASK : '0);
    paddr_o     = {ea[XLEN-1:LANE_W], ea[LANE_W-1:0] ^ (reverse_endian_i ? HALF_MASK : '0)};
    lane_data_o = {{(XLEN-WORD_W){1'b0}}, data_i} << {bytesel, 3'b000};
    lane_be_o   = {{(BYTES-WBYTES){1'b0}}, {WBYTES{1'b1}}} << bytesel;
  end
endmodule

// File: rtl/llsc_link.sv
module llsc_link #(
  parameter int TAG_W = 62
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             sc_i,
  input  logic             exc_i,
  input  logic             snoop_i,
  input  logic [TAG_W-1:0] snoop_tag_i,
  output logic             link_o
);
  logic [TAG_W-1:0] tag_q;
  logic             snoop_hit;

  assign snoop_hit = snoop_i && (snoop_tag_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_o <= 1'b0;
      tag_q  <= '0;
    end else if (set_i) begin
      link_o <= 1'b1;
      tag_q  <= tag_i;
    end else if (sc_i || exc_i || snoop_hit) begin
      link_o <= 1'b0;
    end
  end

  a_r8_sc_clears_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_i && !set_i |=> !link_o);
  a_r8_set_opens_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> link_o);
  a_r9_snoop_clears_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_hit && !set_i |=> !link_o);
  a_r10_exc_clears_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i && !set_i |=> !link_o);
endmodule

// File: rtl/llsc_unit.sv
module llsc_unit
  import llsc_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int OFS_W  = 9,
  parameter int WORD_W = 32,
  localparam int BYTES   = XLEN / 8,
  localparam int ALIGN_W = $clog2(WORD_W / 8),
  localparam int TAG_W   = XLEN - ALIGN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_op_i,
  input  logic [XLEN-1:0]   req_base_i,
  input  logic [OFS_W-1:0]  req_offset_i,
  input  logic [WORD_W-1:0] req_data_i,
  output logic              req_ready_o,
  input  logic              big_endian_i,
  input  logic              reverse_endian_i,
  input  logic              exc_taken_i,
  input  logic              snoop_valid_i,
  input  logic [TAG_W-1:0]  snoop_tag_i,
  output logic              mem_req_o,
  input  logic              mem_ready_i,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic              done_o,
  output logic [XLEN-1:0]   result_o,
  output logic              addr_err_o
);
  llsc_state_e       state_q;
  logic [TAG_W-1:0]  tag;
  logic              misalign, link;
  logic [XLEN-1:0]   paddr, lane_data;
  logic [BYTES-1:0]  lane_be;
  logic              accept, ll_set, sc_fire, go_write;
  logic              result_q, err_q;

  llsc_agen #(.XLEN(XLEN), .OFS_W(OFS_W), .WORD_W(WORD_W)) u_agen (
    .base_i           (req_base_i),
    .offset_i         (req_offset_i),
    .data_i           (req_data_i),
    .big_endian_i     (big_endian_i),
    .reverse_endian_i (reverse_endian_i),
    .tag_o            (tag),
    .misalign_o       (misalign),
    .paddr_o          (paddr),
    .lane_data_o      (lane_data),
    .lane_be_o        (lane_be)
  );

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign ll_set   = accept && (req_op_i == OP_LL) && !misalign;
  assign sc_fire  = accept && (req_op_i == OP_SC);
  assign go_write = sc_fire && !misalign && link;

  llsc_link #(.TAG_W(TAG_W)) u_link (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (ll_set),
    .tag_i       (tag),
    .sc_i        (sc_fire),
    .exc_i       (exc_taken_i),
    .snoop_i     (snoop_valid_i),
    .snoop_tag_i (snoop_tag_i),
    .link_o      (link)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      result_q    <= 1'b0;
      err_q       <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_be_o    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (go_write) begin
            state_q     <= ST_WRITE;
            mem_addr_o  <= paddr;
            mem_wdata_o <= lane_data;
            mem_be_o    <= lane_be;
          end else begin
            state_q  <= ST_RESP;
            result_q <= 1'b0;
            err_q    <= misalign;
          end
        end
        ST_WRITE: if (mem_ready_i) begin
          state_q  <= ST_RESP;
          result_q <= 1'b1;
          err_q    <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_WRITE);
  assign done_o      = (state_q == ST_RESP);
  assign addr_err_o  = done_o && err_q;
  assign result_o    = {{(XLEN-1){1'b0}}, result_q};

  a_r2_aligned_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[ALIGN_W-1:0] == '0);
  a_r3_write_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i |=> done_o && result_o == XLEN'(1));
  a_r4_result_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o[XLEN-1:1] == '0);
  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_be_o));
  a_r6_be_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $countones(mem_be_o) == 4 && (mem_be_o == 8'h0F || mem_be_o == 8'hF0));
  a_r11_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || mem_req_o) |-> !req_ready_o);
endmodule

// File: tb/llsc_unit_test.sv
`timescale 1ns/1ps
module llsc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_op = 1'b0;
  logic [63:0] req_base = '0;
  logic [8:0]  req_offset = '0;
  logic [31:0] req_data = '0;
  logic        req_ready;
  logic        big_en = 1'b0, rev_en = 1'b0, exc = 1'b0, snoop = 1'b0;
  logic [61:0] snoop_tag = '0;
  logic        mem_req, mem_ready = 1'b0;
  logic [63:0] mem_addr, mem_wdata, result;
  logic [7:0]  mem_be;
  logic        done, addr_err;

  int tests = 0, fails = 0, cycles = 0;
  logic [63:0] mem [0:511];

  logic [63:0] r_res, r_addr, r_wdata;
  logic [7:0]  r_be;
  logic        r_err, r_stable;
  int          r_nwr;

  always #2.5 clk = ~clk;

  llsc_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_base_i(req_base), .req_offset_i(req_offset), .req_data_i(req_data),
    .req_ready_o(req_ready), .big_endian_i(big_en), .reverse_endian_i(rev_en),
    .exc_taken_i(exc), .snoop_valid_i(snoop), .snoop_tag_i(snoop_tag),
    .mem_req_o(mem_req), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .done_o(done),
    .result_o(result), .addr_err_o(addr_err)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check(1'b0, "watchdog", 64'(cycles), 64'd150000);
        summary();
      end
    end
  end

  // issue one op; dly = memory stall cycles before ready
  task automatic run_op(input logic sc, input logic [63:0] base, input logic [8:0] off,
                        input logic [31:0] data, input int dly);
    int cnt = 0;
    bit seen = 0;
    r_nwr = 0; r_err = 0; r_res = '1; r_stable = 1;
    @(negedge clk);
    req_valid = 1; req_op = sc; req_base = base; req_offset = off; req_data = data;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 60; i++) begin
      if (mem_req) begin
        if (!seen) begin
          seen = 1; r_addr = mem_addr; r_wdata = mem_wdata; r_be = mem_be;
        end else if (mem_addr != r_addr || mem_wdata != r_wdata || mem_be != r_be) r_stable = 0;
        cnt++;
        if (cnt > dly) begin
          mem_ready = 1; r_nwr++;
          for (int b = 0; b < 8; b++)
            if (mem_be[b]) mem[mem_addr[11:3]][8*b +: 8] = mem_wdata[8*b +: 8];
        end else mem_ready = 0;
      end else begin
        mem_ready = 0;
        if (done) begin
          r_res = result; r_err = addr_err;
          break;
        end
      end
      @(negedge clk);
    end
    mem_ready = 0;
  endtask

  task automatic pulse_snoop(input logic [63:0] addr);
    @(negedge clk); snoop = 1; snoop_tag = addr[63:2];
    @(negedge clk); snoop = 0;
  endtask

  task automatic pulse_exc();
    @(negedge clk); exc = 1;
    @(negedge clk); exc = 0;
  endtask

  task automatic t_reset();
    check(req_ready === 1'b1, "R11 ready after reset", 64'(req_ready), 64'd1);
    check(done === 1'b0 && mem_req === 1'b0, "R11 idle after reset", {62'd0, done, mem_req}, 64'd0);
  endtask

  task automatic t_basic();
    run_op(1'b0, 64'h100, 9'd0, 32'h0, 0);
    check(r_res == 64'd0 && r_nwr == 0, "R11 LL result", r_res, 64'd0);
    fork
      run_op(1'b1, 64'h100, 9'd0, 32'hAABBCCDD, 3);
      begin
        @(negedge clk); @(negedge clk);
        check(req_ready == 1'b0, "R11 busy not ready", 64'(req_ready), 64'd0);
      end
    join
    check(r_res == 64'd1, "R3 SC success", r_res, 64'd1);
    check(r_nwr == 1, "R3 one write", 64'(r_nwr), 64'd1);
    check(r_addr == 64'h100, "R1 address", r_addr, 64'h100);
    check(r_wdata == 64'hAABBCCDD && r_be == 8'h0F, "R6 lane 0", r_wdata, 64'hAABBCCDD);
    check(r_stable == 1'b1, "R5 hold during stall", 64'(r_stable), 64'd1);
  endtask

  task automatic t_fail();
    run_op(1'b1, 64'h100, 9'd0, 32'h1, 0);
    check(r_res == 64'd0 && r_nwr == 0, "R8 R4 SC after SC fails", r_res, 64'd0);
  endtask

  task automatic t_offset();
    run_op(1'b0, 64'h208, 9'h1F8, 32'h0, 0); // -8
    run_op(1'b1, 64'h104, 9'h0FC, 32'h5, 1); // +252
    check(r_res == 64'd1 && r_addr == 64'h200, "R1 signed offsets", r_addr, 64'h200);
  endtask

  task automatic t_lanes();
    big_en = 1;
    run_op(1'b0, 64'h300, 9'd0, 32'h0, 0);
    run_op(1'b1, 64'h300, 9'd0, 32'h12345678, 0);
    check(r_be == 8'hF0 && r_wdata == 64'h12345678_00000000, "R6 big-endian upper half", r_wdata, 64'h12345678_00000000);
    run_op(1'b0, 64'h304, 9'd0, 32'h0, 0);
    run_op(1'b1, 64'h304, 9'd0, 32'h9ABCDEF0, 0);
    check(r_be == 8'h0F && r_wdata == 64'h9ABCDEF0, "R6 big-endian lower half", r_wdata, 64'h9ABCDEF0);
    big_en = 0; rev_en = 1;
    run_op(1'b0, 64'h300, 9'd0, 32'h0, 0);
    run_op(1'b1, 64'h300, 9'd0, 32'h1, 0);
    check(r_addr == 64'h304 && r_be == 8'h0F, "R7 reverse-endian address", r_addr, 64'h304);
    rev_en = 0;
  endtask

  task automatic t_misalign();
    run_op(1'b0, 64'h100, 9'd0, 32'h0, 0);
    run_op(1'b1, 64'h101, 9'd0, 32'h7, 0);
    check(r_err == 1'b1 && r_nwr == 0 && r_res == 0, "R2 misaligned SC", {63'd0, r_err}, 64'd1);
    run_op(1'b0, 64'h102, 9'd0, 32'h0, 0);
    check(r_err == 1'b1, "R2 misaligned LL error", {63'd0, r_err}, 64'd1);
    run_op(1'b1, 64'h100, 9'd0, 32'h7, 0);
    check(r_res == 0 && r_nwr == 0, "R2 misaligned LL opens nothing", r_res, 64'd0);
  endtask

  task automatic t_snoop();
    run_op(1'b0, 64'h400, 9'd0, 32'h0, 0);
    pulse_snoop(64'h408);
    run_op(1'b1, 64'h400, 9'd0, 32'h3, 0);
    check(r_res == 64'd1, "R9 other-word snoop keeps link", r_res, 64'd1);
    run_op(1'b0, 64'h400, 9'd0, 32'h0, 0);
    pulse_snoop(64'h402);
    run_op(1'b1, 64'h400, 9'd0, 32'h4, 0);
    check(r_res == 64'd0 && r_nwr == 0, "R9 same-word snoop clears", r_res, 64'd0);
  endtask

  task automatic t_exc();
    run_op(1'b0, 64'h480, 9'd0, 32'h0, 0);
    pulse_exc();
    run_op(1'b1, 64'h480, 9'd0, 32'h4, 0);
    check(r_res == 64'd0 && r_nwr == 0, "R10 exception clears link", r_res, 64'd0);
  endtask

  task automatic t_loop();
    int ref_cnt = 0, tries = 0;
    logic [31:0] v;
    mem[64'h500 >> 3] = '0;
    while (ref_cnt < 8 && tries < 40) begin
      tries++;
      run_op(1'b0, 64'h500, 9'd0, 32'h0, 0);
      v = mem[64'h500 >> 3][31:0];
      if (tries % 3 == 1) pulse_snoop(64'h500);
      else if (tries % 5 == 2) pulse_exc();
      run_op(1'b1, 64'h500, 9'd0, v + 32'd1, tries % 3);
      if (r_res == 64'd1) ref_cnt++;
    end
    check(mem[64'h500 >> 3][31:0] == 32'(ref_cnt) && ref_cnt == 8, "R3 R4 increment loop",
          {32'd0, mem[64'h500 >> 3][31:0]}, 64'(ref_cnt));
    check(tries > ref_cnt, "R9 R10 retries seen", 64'(tries), 64'(ref_cnt));
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_fail();
    t_offset();
    t_lanes();
    t_misalign();
    t_snoop();
    t_exc();
    t_loop();
    summary();
  end
endmodule